// File: doc/BRIEF.md
# Single-Cycle Integer Fetch-Execute Core

This block is a minimal processor loop for a 32-bit register-to-register integer instruction subset. In every clock cycle it presents the word index of its program counter to an external instruction memory and takes back one 32-bit instruction word. It decodes that word, computes a result from registers or an embedded constant, and writes the result into a 32-entry register file. On the same edge it moves the program counter on by four bytes. No instruction touches data memory, and control never leaves the straight-line sequence.

The instruction memory port is read combinationally, so the fetched word belongs to the cycle in which its address appears. Debug outputs show the current program counter, the instruction being executed and the register write it will perform at the next rising edge. A testbench can follow execution one instruction at a time with these outputs.

Top module: `core_seq`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter and every register become zero. The first instruction after reset reads zero from any register.
- R2: Each rising edge without reset advances the program counter by 4. `imem_addr` is always the program counter shifted right by two, and the counter's two low bits stay zero.
- R3: A `RESET_PC` parameter with nonzero low bits is aligned down to a multiple of 4. For example, 6 gives 4.
- R4: R-type instructions (opcode 0; rs = bits 25:21, rt = bits 20:16, rd = bits 15:11) with funct 0x20 or 0x21 write rs+rt to rd, and funct 0x22 or 0x23 write rs-rt. All four wrap modulo 2^32 and never trap.
- R5: Funct 0x24, 0x25, 0x26 and 0x27 write rs AND rt, rs OR rt, rs XOR rt and NOT(rs OR rt) respectively.
- R6: Funct 0x2A writes 1 if rs < rt as signed numbers and 0 otherwise. Funct 0x2B does the same comparison unsigned.
- R7: Funct 0x00, 0x02 and 0x03 shift rt left, right logically, or right arithmetically by bits 10:6. Funct 0x04, 0x06 and 0x07 do the same shifts by rs[4:0].
- R8: I-type instructions (16-bit immediate in bits 15:0, destination rt) behave as follows. Opcodes 0x08 and 0x09 add the sign-extended immediate. Opcode 0x0A compares against the sign-extended immediate as signed numbers, and 0x0B compares against it as unsigned numbers. Opcodes 0x0C, 0x0D and 0x0E apply AND, OR and XOR with the zero-extended immediate. Opcode 0x0F writes the immediate into the upper half with zeros below.
- R9: Register 0 always reads as zero. An instruction targeting it leaves it unchanged and shows `dbg_we` low.
- R10: Instructions complete in program order. An instruction reads the results of every earlier instruction, including the one immediately before it, and an instruction that reads and writes the same register sees the old value.
- R11: Any opcode outside R8, or any opcode-0 funct outside R4 to R7, writes nothing and shows `dbg_we` low.
- R12: `dbg_pc` and `dbg_instr` show the address and word of the instruction executing this cycle. `dbg_rd` and `dbg_wdata` show the write it will commit at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 30 | Word index of the instruction to fetch |
| imem_rdata | input | 32 | Instruction word returned for `imem_addr` |
| dbg_pc | output | 32 | Byte address of the executing instruction |
| dbg_instr | output | 32 | Executing instruction word |
| dbg_we | output | 1 | A register write commits at the next edge |
| dbg_rd | output | 5 | Destination register index |
| dbg_wdata | output | 32 | Value being written |

## Verification
The bench drives several edge cases. Immediates with the top bit set catch a design that mixes up sign and zero extension; it would print wrong values after `andi` or `sltiu`. Operand pairs with opposite signs catch a signed/unsigned compare swap. Variable shift amounts above 31 would expose a design that does not mask the amount to five bits. Writes aimed at register 0, followed by reads of it, catch a file that stores into entry zero. Chains of dependent instructions and read-modify-write of one register catch a design whose reads see the new value, or a stale one. A second reset in the middle of the run, and an instance with a misaligned reset address, show whether the registers clear and whether the counter is aligned.

// File: rtl/core_seq_pkg.sv
package core_seq_pkg;

  localparam int RIDX_W = 5;
  localparam int NREG   = 1 << RIDX_W;

  localparam logic [5:0] OPC_RTYPE = 6'h00;
  localparam logic [5:0] OPC_ADDI  = 6'h08;
  localparam logic [5:0] OPC_ADDIU = 6'h09;
  localparam logic [5:0] OPC_SLTI  = 6'h0A;
  localparam logic [5:0] OPC_SLTIU = 6'h0B;
  localparam logic [5:0] OPC_ANDI  = 6'h0C;
  localparam logic [5:0] OPC_ORI   = 6'h0D;
  localparam logic [5:0] OPC_XORI  = 6'h0E;
  localparam logic [5:0] OPC_LUI   = 6'h0F;

  localparam logic [5:0] FN_SLL  = 6'h00;
  localparam logic [5:0] FN_SRL  = 6'h02;
  localparam logic [5:0] FN_SRA  = 6'h03;
  localparam logic [5:0] FN_SLLV = 6'h04;
  localparam logic [5:0] FN_SRLV = 6'h06;
  localparam logic [5:0] FN_SRAV = 6'h07;
  localparam logic [5:0] FN_ADD  = 6'h20;
  localparam logic [5:0] FN_ADDU = 6'h21;
  localparam logic [5:0] FN_SUB  = 6'h22;
  localparam logic [5:0] FN_SUBU = 6'h23;
  localparam logic [5:0] FN_AND  = 6'h24;
  localparam logic [5:0] FN_OR   = 6'h25;
  localparam logic [5:0] FN_XOR  = 6'h26;
  localparam logic [5:0] FN_NOR  = 6'h27;
  localparam logic [5:0] FN_SLT  = 6'h2A;
  localparam logic [5:0] FN_SLTU = 6'h2B;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_NOR,
    ALU_SLT, ALU_SLTU, ALU_SLL, ALU_SRL, ALU_SRA, ALU_LUI
  } alu_op_e;

  typedef struct packed {
    logic              we;
    alu_op_e           op;
    logic              use_imm;
    logic              shamt_var;
    logic [RIDX_W-1:0] dst;
  } ctrl_t;

endpackage

// File: rtl/core_pc.sv
module core_pc #(
  parameter int          XLEN     = 32,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic            clk,
  input  logic            rst,
  output logic [XLEN-1:0] pc
);
  localparam logic [XLEN-1:0] START = XLEN'(RESET_PC) & ~XLEN'(3);
  localparam logic [XLEN-1:0] STEP  = XLEN'(4);

  logic [XLEN-1:0] pc_q;

  always_ff @(posedge clk) begin
    if (rst) pc_q <= START;
    else     pc_q <= pc_q + STEP;
  end

  assign pc = pc_q;

  assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> pc_q == $past(pc_q) + STEP);

  assert_pc_aligned_R2: assert property (@(posedge clk) disable iff (rst)
    pc_q[1:0] == 2'b00);

  assert_pc_reset_R3: assert property (@(posedge clk)
    ($past(rst) && !rst) |-> pc_q == START);

endmodule

// File: rtl/core_regfile.sv
module core_regfile
  import core_seq_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RIDX_W-1:0] ra_idx,
  input  logic [RIDX_W-1:0] rb_idx,
  output logic [XLEN-1:0]   ra_data,
  output logic [XLEN-1:0]   rb_data,
  input  logic              we,
  input  logic [RIDX_W-1:0] wa,
  input  logic [XLEN-1:0]   wd
);
  logic [XLEN-1:0] regs [NREG];
  logic            wr_ok;

  assign wr_ok = we && (wa != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (wr_ok) begin
      regs[wa] <= wd;
    end
  end

  assign ra_data = (ra_idx == '0) ? '0 : regs[ra_idx];
  assign rb_data = (rb_idx == '0) ? '0 : regs[rb_idx];

  assert_write_lands_R10: assert property (@(posedge clk) disable iff (rst)
    (we && wa != '0) |=> regs[$past(wa)] == $past(wd));

  assert_zero_entry_R9: assert property (@(posedge clk) disable iff (rst)
    regs[0] == '0);

endmodule

// File: rtl/core_decode.sv
module core_decode
  import core_seq_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [31:0]     instr,
  output ctrl_t           ctrl,
  output logic [XLEN-1:0] imm
);
  logic [5:0]  opc, fn;
  logic [15:0] imm16;
  logic [XLEN-1:0] imm_s, imm_z;

  assign opc   = instr[31:26];
  assign fn    = instr[5:0];
  assign imm16 = instr[15:0];
  assign imm_s = XLEN'($signed(imm16));
  assign imm_z = XLEN'(imm16);

  always_comb begin
    ctrl = '0;
    ctrl.op = ALU_ADD;
    imm  = imm_z;
    if (opc == OPC_RTYPE) begin
      ctrl.dst = instr[15:11];
      ctrl.we  = 1'b1;
      case (fn)
        FN_ADD, FN_ADDU: ctrl.op = ALU_ADD;
        FN_SUB, FN_SUBU: ctrl.op = ALU_SUB;
        FN_AND:  ctrl.op = ALU_AND;
        FN_OR:   ctrl.op = ALU_OR;
        FN_XOR:  ctrl.op = ALU_XOR;
        FN_NOR:  ctrl.op = ALU_NOR;
        FN_SLT:  ctrl.op = ALU_SLT;
        FN_SLTU: ctrl.op = ALU_SLTU;
        FN_SLL:  ctrl.op = ALU_SLL;
        FN_SRL:  ctrl.op = ALU_SRL;
        FN_SRA:  ctrl.op = ALU_SRA;
        FN_SLLV: begin ctrl.op = ALU_SLL; ctrl.shamt_var = 1'b1; end
        FN_SRLV: begin ctrl.op = ALU_SRL; ctrl.shamt_var = 1'b1; end
        FN_SRAV: begin ctrl.op = ALU_SRA; ctrl.shamt_var = 1'b1; end
        default: ctrl.we = 1'b0;
      endcase
    end else begin
      ctrl.dst     = instr[20:16];
      ctrl.use_imm = 1'b1;
      ctrl.we      = 1'b1;
      case (opc)
        OPC_ADDI, OPC_ADDIU: begin ctrl.op = ALU_ADD;  imm = imm_s; end
        OPC_SLTI:            begin ctrl.op = ALU_SLT;  imm = imm_s; end
        OPC_SLTIU:           begin ctrl.op = ALU_SLTU; imm = imm_s; end
        OPC_ANDI: ctrl.op = ALU_AND;
        OPC_ORI:  ctrl.op = ALU_OR;
        OPC_XORI: ctrl.op = ALU_XOR;
        OPC_LUI:  ctrl.op = ALU_LUI;
        default:  ctrl.we = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/core_alu.sv
module core_alu
  import core_seq_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  alu_op_e          op,
  input  logic [XLEN-1:0]  a,
  input  logic [XLEN-1:0]  b,
  input  logic [$clog2(XLEN)-1:0] sh,
  output logic [XLEN-1:0]  y
);
  localparam int HALF = XLEN / 2;

  always_comb begin
    case (op)
      ALU_ADD:  y = a + b;
      ALU_SUB:  y = a - b;
      ALU_AND:  y = a & b;
      ALU_OR:   y = a | b;
      ALU_XOR:  y = a ^ b;
      ALU_NOR:  y = ~(a | b);
      ALU_SLT:  y = XLEN'($signed(a) < $signed(b));
      ALU_SLTU: y = XLEN'(a < b);
      ALU_SLL:  y = b << sh;
      ALU_SRL:  y = b >> sh;
      ALU_SRA:  y = XLEN'($signed(b) >>> sh);
      ALU_LUI:  y = b << HALF;
      default:  y = '0;
    endcase
  end

endmodule

// File: rtl/core_seq.sv
module core_seq
  import core_seq_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic              clk,
  input  logic              rst,
  output logic [XLEN-3:0]   imem_addr,
  input  logic [31:0]       imem_rdata,
  output logic [XLEN-1:0]   dbg_pc,
  output logic [31:0]       dbg_instr,
  output logic              dbg_we,
  output logic [RIDX_W-1:0] dbg_rd,
  output logic [XLEN-1:0]   dbg_wdata
);
  localparam int SH_W = $clog2(XLEN);

  logic [XLEN-1:0] pc, ra_data, rb_data, imm, opb, result;
  logic [SH_W-1:0] sh_amt;
  ctrl_t           ctrl;
  logic            commit;

  core_pc #(.XLEN(XLEN), .RESET_PC(RESET_PC)) u_pc (
    .clk(clk), .rst(rst), .pc(pc)
  );

  assign imem_addr = pc[XLEN-1:2];

  core_decode #(.XLEN(XLEN)) u_dec (
    .instr(imem_rdata), .ctrl(ctrl), .imm(imm)
  );

  core_regfile #(.XLEN(XLEN)) u_rf (
    .clk(clk), .rst(rst),
    .ra_idx(imem_rdata[25:21]), .rb_idx(imem_rdata[20:16]),
    .ra_data(ra_data), .rb_data(rb_data),
    .we(ctrl.we), .wa(ctrl.dst), .wd(result)
  );

  assign opb    = ctrl.use_imm ? imm : rb_data;
  assign sh_amt = ctrl.shamt_var ? ra_data[SH_W-1:0] : imem_rdata[6 +: SH_W];

  core_alu #(.XLEN(XLEN)) u_alu (
    .op(ctrl.op), .a(ra_data), .b(opb), .sh(sh_amt), .y(result)
  );

  assign commit    = ctrl.we && (ctrl.dst != '0);
  assign dbg_pc    = pc;
  assign dbg_instr = imem_rdata;
  assign dbg_we    = commit;
  assign dbg_rd    = ctrl.dst;
  assign dbg_wdata = result;

  assert_dst_zero_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (dbg_rd == '0) |-> !dbg_we);

endmodule

// File: tb/test_core_seq.sv
module test_core_seq;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [31:0] pc;
    logic [31:0] instr;
    logic        we;
    logic [4:0]  rd;
    logic [31:0] wd;
    string       req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [29:0] imem_addr, odd_addr;
  logic [31:0] imem_rdata;
  logic [31:0] dbg_pc, dbg_instr, dbg_wdata, odd_pc, odd_instr, odd_wdata;
  logic        dbg_we, odd_we;
  logic [4:0]  dbg_rd, odd_rd;

  logic [31:0] imem [256];
  logic [31:0] mreg [32];
  logic [31:0] mpc;
  exp_t        q[$];
  logic        mon_en = 1'b0;
  int          n_vec = 0;
  int          n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign imem_rdata = imem[imem_addr[7:0]];

  core_seq i_core_seq (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dbg_pc(dbg_pc), .dbg_instr(dbg_instr), .dbg_we(dbg_we),
    .dbg_rd(dbg_rd), .dbg_wdata(dbg_wdata)
  );

  core_seq #(.RESET_PC(32'h6)) i_core_seq_odd (
    .clk(clk), .rst(rst), .imem_addr(odd_addr), .imem_rdata(32'h0),
    .dbg_pc(odd_pc), .dbg_instr(odd_instr), .dbg_we(odd_we),
    .dbg_rd(odd_rd), .dbg_wdata(odd_wdata)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rt_enc(input logic [5:0] fn, input logic [4:0] rd,
      input logic [4:0] rs, input logic [4:0] rt, input logic [4:0] sh);
    return {6'h00, rs, rt, rd, sh, fn};
  endfunction

  function automatic logic [31:0] it_enc(input logic [5:0] op, input logic [4:0] rt,
      input logic [4:0] rs, input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  // Driver: writes the word to memory, runs the reference model, queues the expectation.
  task automatic push(input logic [31:0] ins, input string req);
    logic [5:0] op, fn;
    logic [4:0] rs, rt, rd, sh, dst;
    logic [31:0] a, b, se, ze, v;
    logic ok;
    exp_t e;
    op = ins[31:26]; rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11];
    sh = ins[10:6];  fn = ins[5:0];
    a = mreg[rs]; b = mreg[rt];
    se = {{16{ins[15]}}, ins[15:0]}; ze = {16'h0, ins[15:0]};
    ok = 1'b1; v = 32'h0; dst = rt;
    if (op == 6'h00) begin
      dst = rd;
      case (fn)
        6'h20, 6'h21: v = a + b;
        6'h22, 6'h23: v = a - b;
        6'h24: v = a & b;
        6'h25: v = a | b;
        6'h26: v = a ^ b;
        6'h27: v = ~(a | b);
        6'h2A: v = {31'h0, $signed(a) < $signed(b)};
        6'h2B: v = {31'h0, a < b};
        6'h00: v = b << sh;
        6'h02: v = b >> sh;
        6'h03: v = $signed(b) >>> sh;
        6'h04: v = b << a[4:0];
        6'h06: v = b >> a[4:0];
        6'h07: v = $signed(b) >>> a[4:0];
        default: ok = 1'b0;
      endcase
    end else begin
      case (op)
        6'h08, 6'h09: v = a + se;
        6'h0A: v = {31'h0, $signed(a) < $signed(se)};
        6'h0B: v = {31'h0, a < se};
        6'h0C: v = a & ze;
        6'h0D: v = a | ze;
        6'h0E: v = a ^ ze;
        6'h0F: v = {ins[15:0], 16'h0};
        default: ok = 1'b0;
      endcase
    end
    e.pc = mpc; e.instr = ins; e.we = ok && (dst != 5'd0);
    e.rd = dst; e.wd = v; e.req = req;
    if (e.we) mreg[dst] = v;
    imem[mpc[9:2]] = ins;
    mpc = mpc + 32'd4;
    q.push_back(e);
  endtask

  // Monitor: compares the debug outputs against the queue in mid-cycle.
  always @(negedge clk) begin
    #1;
    if (mon_en && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check("R12", "dbg_pc", dbg_pc, e.pc);
      check("R2", "imem_addr", {2'b00, imem_addr}, e.pc >> 2);
      check("R12", "dbg_instr", dbg_instr, e.instr);
      check(e.req, "dbg_we", {31'h0, dbg_we}, {31'h0, e.we});
      if (e.we) begin
        check(e.req, "dbg_rd", {27'h0, dbg_rd}, {27'h0, e.rd});
        check(e.req, "dbg_wdata", dbg_wdata, e.wd);
      end
    end
  end

  task automatic model_reset();
    for (int i = 0; i < 32; i++) mreg[i] = 32'h0;
    mpc = 32'h0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) imem[i] = 32'h0;
    model_reset();
    push(rt_enc(6'h21, 5'd1, 5'd2, 5'd3, 5'd0), "R1");
    push(it_enc(6'h09, 5'd1, 5'd0, 16'h7FFF), "R8");
    push(it_enc(6'h08, 5'd2, 5'd0, 16'hFFFD), "R8");
    push(it_enc(6'h0F, 5'd3, 5'd0, 16'h8000), "R8");
    push(it_enc(6'h0D, 5'd3, 5'd3, 16'h1234), "R10");
    push(rt_enc(6'h20, 5'd4, 5'd3, 5'd3, 5'd0), "R4");
    push(rt_enc(6'h22, 5'd5, 5'd0, 5'd1, 5'd0), "R4");
    push(rt_enc(6'h23, 5'd6, 5'd2, 5'd3, 5'd0), "R4");
    push(rt_enc(6'h24, 5'd7, 5'd2, 5'd3, 5'd0), "R5");
    push(rt_enc(6'h25, 5'd8, 5'd2, 5'd3, 5'd0), "R5");
    push(rt_enc(6'h26, 5'd9, 5'd2, 5'd3, 5'd0), "R5");
    push(rt_enc(6'h27, 5'd10, 5'd1, 5'd3, 5'd0), "R5");
    push(rt_enc(6'h2A, 5'd11, 5'd3, 5'd1, 5'd0), "R6");
    push(rt_enc(6'h2B, 5'd12, 5'd3, 5'd1, 5'd0), "R6");
    push(rt_enc(6'h2A, 5'd11, 5'd1, 5'd3, 5'd0), "R6");
    push(rt_enc(6'h00, 5'd13, 5'd0, 5'd3, 5'd4), "R7");
    push(rt_enc(6'h02, 5'd14, 5'd0, 5'd3, 5'd4), "R7");
    push(rt_enc(6'h03, 5'd15, 5'd0, 5'd3, 5'd4), "R7");
    push(it_enc(6'h09, 5'd16, 5'd0, 16'd36), "R8");
    push(rt_enc(6'h04, 5'd17, 5'd16, 5'd2, 5'd0), "R7");
    push(rt_enc(6'h06, 5'd18, 5'd16, 5'd3, 5'd0), "R7");
    push(rt_enc(6'h07, 5'd19, 5'd16, 5'd3, 5'd0), "R7");
    push(it_enc(6'h0A, 5'd20, 5'd2, 16'hFFFE), "R8");
    push(it_enc(6'h0B, 5'd21, 5'd1, 16'hFFFF), "R8");
    push(it_enc(6'h0C, 5'd22, 5'd2, 16'hFFFF), "R8");
    push(it_enc(6'h0E, 5'd23, 5'd2, 16'h80FF), "R8");
    push(it_enc(6'h09, 5'd0, 5'd0, 16'd5), "R9");
    push(rt_enc(6'h21, 5'd0, 5'd2, 5'd3, 5'd0), "R9");
    push(rt_enc(6'h21, 5'd24, 5'd0, 5'd0, 5'd0), "R9");
    push({6'h3F, 26'h0421000}, "R11");
    push(rt_enc(6'h3F, 5'd26, 5'd1, 5'd2, 5'd0), "R11");
    push(rt_enc(6'h21, 5'd26, 5'd26, 5'd0, 5'd0), "R11");
    push(it_enc(6'h09, 5'd25, 5'd25, 16'd1), "R10");
    push(it_enc(6'h09, 5'd25, 5'd25, 16'd1), "R10");
    push(it_enc(6'h09, 5'd25, 5'd25, 16'd1), "R10");
    push(rt_enc(6'h21, 5'd27, 5'd25, 5'd4, 5'd0), "R10");
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    mon_en = 1'b1;
    check("R1", "pc after reset", dbg_pc, 32'h0);
    #2;
    check("R3", "aligned reset pc", odd_pc, 32'h4);
    @(negedge clk);
    #2;
    check("R3", "aligned pc step", odd_pc, 32'h8);
    wait (q.size() == 0);
    @(negedge clk);
    mon_en = 1'b0;
    rst = 1'b1;
    model_reset();
    push(rt_enc(6'h21, 5'd1, 5'd25, 5'd3, 5'd0), "R1");
    push(rt_enc(6'h25, 5'd2, 5'd4, 5'd27, 5'd0), "R1");
    push(it_enc(6'h0D, 5'd3, 5'd22, 16'hA5A5), "R1");
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    mon_en = 1'b1;
    wait (q.size() == 0);
    @(negedge clk);
    mon_en = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule